// File: doc/BRIEF.md
# Normalization Shift Selector

This block looks at a wide word, typically the raw magnitude from a floating-point add or subtract, and marks its most significant set bit. The result is a one-hot vector, not a binary index. That vector can go straight to one operand of a hardware multiplier, which then acts as a left shifter and normalizes the mantissa without a separate decoder.

The word is split into an upper and a lower group of equal width. Each group finds its own leading one through a ripple chain of "seen a one yet" taps. A wide NOR over the upper group decides whether the lower group's mark may pass. The combined mark is registered, together with an all-zero flag, a binary leading-zero count for cross-checking, and a delayed copy of the input-valid strobe.

Top module: `norm_shift_select`

## Requirements
- R1: `mark_q` never has more than one bit set. When the word has any bit set, the single set bit of `mark_q` sits at the index of the word's highest set bit, with bit 17 the most significant.
- R2: When any bit of the upper group (bits 17..9) is set, bits 8..0 of `mark_q` are all zero, whatever the lower group holds.
- R3: When the upper group is all zero, `mark_q` bits 17..9 are zero and bits 8..0 mark the highest set bit of the lower group.
- R4: Results take one clock. The word present at a rising edge is reflected in the outputs right after that edge. The word is sampled on every edge, whatever the value of `in_valid`.
- R5: An all-zero word gives `mark_q` equal to 0 and `zero_q` equal to 1. Any nonzero word gives `zero_q` equal to 0.
- R6: `lzc_q` (5 bits) equals 17 minus the index of the marked bit. It reads 0 for an all-zero word.
- R7: A synchronous, active-high `rst` sampled at an edge sets `mark_q`, `zero_q`, `lzc_q` and `out_valid` to 0 after that edge.
- R8: `out_valid` after an edge equals `in_valid` sampled at that edge, except under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_word` |
| in_word | input | 18 | Word to normalize |
| out_valid | output | 1 | `in_valid` delayed one cycle |
| mark_q | output | 18 | Registered one-hot shift control |
| zero_q | output | 1 | Registered all-zero flag |
| lzc_q | output | 5 | Registered leading-zero count |

## Verification
The bench builds the block with its default group width of 9, so the word is 18 bits and the count is 5 bits. At that size a walking one reaches each of the 18 mark positions and both extremes of the count (0 and 17). Mixed words with bits set in both groups show that the upper-group NOR suppresses the lower mark. A stream of pseudo-random words, with valid toggling and a reset inserted mid-stream, covers R4, R7 and R8 against a scoreboard.

// File: rtl/norm_shift_pkg.sv
package norm_shift_pkg;
    // Default width of one priority group; the word holds two groups.
    localparam int unsigned DEF_GROUP_W = 9;

    // Which group supplies the mark for the current word.
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LOWER = 2'd1,
        SEL_UPPER = 2'd2
    } grp_sel_e;
endpackage

// File: rtl/lead_chain.sv
// Ripple chain: the tap carries 0 above the first set bit and 1 from it
// downward; the XOR of neighbouring taps isolates that first set bit.
module lead_chain #(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] bits,
    output logic [W-1:0] mark,
    output logic         any
);
    logic [W:0] seen;

    assign seen[W] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_tap
        assign seen[i] = seen[i+1] | bits[i];
        assign mark[i] = seen[i] ^ seen[i+1];
    end

    assign any = seen[0];
endmodule

// File: rtl/mark_to_count.sv
// Converts a one-hot mark into a leading-zero count (MSB-relative).
module mark_to_count #(
    parameter int unsigned W  = 18,
    parameter int unsigned CW = 5
) (
    input  logic [W-1:0]  mark,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            if (mark[i]) begin
                count = count | CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/norm_shift_select.sv
module norm_shift_select
    import norm_shift_pkg::*;
#(
    parameter int unsigned GROUP_W = DEF_GROUP_W,
    localparam int unsigned DATA_W = 2 * GROUP_W,
    localparam int unsigned CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] mark_q,
    output logic              zero_q,
    output logic [CNT_W-1:0]  lzc_q
);
    logic [1:0][GROUP_W-1:0] grp_mark;
    logic [1:0]              grp_any;
    logic                    upper_clear;
    grp_sel_e                sel;
    logic [DATA_W-1:0]       mark_d;
    logic [CNT_W-1:0]        lzc_d;

    // Group 0 is the lower half, group 1 the upper half.
    for (genvar g = 0; g < 2; g++) begin : g_grp
        lead_chain #(.W(GROUP_W)) u_chain (
            .bits (in_word[g*GROUP_W +: GROUP_W]),
            .mark (grp_mark[g]),
            .any  (grp_any[g])
        );
    end

    // Wide NOR over the upper half gates the lower half's mark.
    assign upper_clear = ~|in_word[DATA_W-1:GROUP_W];

    always_comb begin
        if (!upper_clear)      sel = SEL_UPPER;
        else if (grp_any[0])   sel = SEL_LOWER;
        else                   sel = SEL_NONE;
    end

    always_comb begin
        unique case (sel)
            SEL_UPPER: mark_d = {grp_mark[1], {GROUP_W{1'b0}}};
            SEL_LOWER: mark_d = {{GROUP_W{1'b0}}, grp_mark[0]};
            SEL_NONE:  mark_d = '0;
            default:   mark_d = '0;
        endcase
    end

    mark_to_count #(.W(DATA_W), .CW(CNT_W)) u_count (
        .mark  (mark_d),
        .count (lzc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q    <= '0;
            zero_q    <= 1'b0;
            lzc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            mark_q    <= mark_d;
            zero_q    <= (sel == SEL_NONE);
            lzc_q     <= lzc_d;
            out_valid <= in_valid;
        end
    end
endmodule

// File: rtl/norm_shift_select_chk.sv
module norm_shift_select_chk #(
    parameter int unsigned GROUP_W = 9,
    localparam int unsigned DATA_W = 2 * GROUP_W,
    localparam int unsigned CNT_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_word,
    input logic              out_valid,
    input logic [DATA_W-1:0] mark_q,
    input logic              zero_q,
    input logic [CNT_W-1:0]  lzc_q
);
    logic [DATA_W-1:0] aligned;
    assign aligned = mark_q << lzc_q;

    // R1
    single_mark_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mark_q));

    // R2
    upper_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|in_word[DATA_W-1:GROUP_W]) |=> (mark_q[GROUP_W-1:0] == '0));

    // R5
    empty_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_word == '0) |=> (zero_q && mark_q == '0));

    // R6
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !zero_q) |-> aligned[DATA_W-1]);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (mark_q == '0 && !zero_q && lzc_q == '0 && !out_valid));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

bind norm_shift_select norm_shift_select_chk #(.GROUP_W(GROUP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .mark_q    (mark_q),
    .zero_q    (zero_q),
    .lzc_q     (lzc_q)
);

// File: tb/norm_shift_select_test.sv
`timescale 1ns/1ps
module norm_shift_select_test;
    localparam int GROUP_W = 9;
    localparam int DATA_W  = 2 * GROUP_W;
    localparam int CNT_W   = $clog2(DATA_W);

    typedef struct {
        logic [DATA_W-1:0] mark;
        logic              zero;
        logic [CNT_W-1:0]  lzc;
        logic              valid;
        logic              in_rst;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_word = '0;
    logic              out_valid;
    logic [DATA_W-1:0] mark_q;
    logic              zero_q;
    logic [CNT_W-1:0]  lzc_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t q[$];
    int unsigned lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;  // 50 MHz

    norm_shift_select #(.GROUP_W(GROUP_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .mark_q(mark_q), .zero_q(zero_q), .lzc_q(lzc_q)
    );

    function automatic exp_t model(logic r, logic v, logic [DATA_W-1:0] w);
        exp_t e;
        e.mark = '0; e.zero = 1'b0; e.lzc = '0; e.valid = 1'b0; e.in_rst = r;
        if (!r) begin
            e.valid = v;
            e.zero  = (w == '0);
            for (int i = DATA_W - 1; i >= 0; i--) begin
                if (w[i] && e.mark == '0) begin
                    e.mark = DATA_W'(1) << i;
                    e.lzc  = CNT_W'(DATA_W - 1 - i);
                end
            end
        end
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: apply one word at the falling edge, queue its expected result.
    task automatic drive(logic r, logic v, logic [DATA_W-1:0] w);
        @(negedge clk);
        rst = r; in_valid = v; in_word = w;
        q.push_back(model(r, v, w));
    endtask

    // Monitor: one quarter period after each rising edge (R4 latency).
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.in_rst) begin
                    check(mark_q == '0 && zero_q == 1'b0 && lzc_q == '0 && out_valid == 1'b0,
                          "R7", "reset outputs", {mark_q, zero_q, out_valid}, 32'h0);
                end else begin
                    check(mark_q == e.mark, "R1/R2/R3/R4", "mark", 32'(mark_q), 32'(e.mark));
                    check(zero_q == e.zero, "R5", "zero flag", 32'(zero_q), 32'(e.zero));
                    check(lzc_q == e.lzc, "R6", "count", 32'(lzc_q), 32'(e.lzc));
                    check(out_valid == e.valid, "R8", "valid", 32'(out_valid), 32'(e.valid));
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        drive(1'b1, 1'b1, '1);
        drive(1'b1, 1'b0, 18'h0_0001);
        // R5: all-zero word
        drive(1'b0, 1'b1, '0);
        // R1, R6: walking one through every position
        for (int i = 0; i < DATA_W; i++) drive(1'b0, 1'b1, DATA_W'(1) << i);
        // R2: upper group wins over any lower content
        drive(1'b0, 1'b1, 18'h0_0200 | 18'h0_01FF);
        drive(1'b0, 1'b1, '1);
        drive(1'b0, 1'b0, 18'h2_0001);
        drive(1'b0, 1'b1, 18'h1_5155);
        // R3: upper group clear, lower group resolves
        drive(1'b0, 1'b1, 18'h0_01FF);
        drive(1'b0, 1'b1, 18'h0_0055);
        drive(1'b0, 1'b0, 18'h0_0003);
        // R4, R8: back-to-back stream with toggling valid
        for (int n = 0; n < 300; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            drive(1'b0, lfsr[20], DATA_W'(lfsr >> (lfsr[3:0])));
            if (n == 150) drive(1'b1, 1'b1, 18'h3_FFFF);  // R7 mid-stream
        end
        drive(1'b0, 1'b0, '0);
        drive(1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule